// File: doc/BRIEF.md
# Pointer justification event counters

The block counts positive and negative pointer justification events for a single tributary. Each kind of event has its own running counter. A performance-monitoring (PM) boundary pulse moves each running count into a 4-bit holding register, which a processor can read through an external decoder, and starts the running counts again from zero.

A configuration bit selects the overflow behaviour. When it is set, a count stops at its maximum. When it is clear, the count wraps to zero. Four alarm levels zero every count while any one of them is active: loss of pointer, tributary AIS, loss of multiframe alignment and an automatic AIS request.

All updates are synchronous to `clk_i`. A strobe or pulse that is high at a rising edge takes effect at that edge and can be seen on the outputs after it.

Top module: `ptr_just_cnt`

## Requirements
- R1: The increment strobe `inc_i` only advances the increment count, and the decrement strobe `dec_i` only advances the decrement count.
- R2: After reset, both holding outputs are 4 bits wide and read 0.
- R3: One cycle after a PM pulse with no alarm active, each holding output equals the running count from before that pulse. At other times, without an alarm, the holding outputs keep their value.
- R4: A PM pulse clears the running counts, so counting in the next period begins at zero.
- R5: With `sat_en_i` = 1, a running count that has reached 15 stays at 15 on further events.
- R6: With `sat_en_i` = 0, an event at count 15 wraps the count to 0. For example, 17 events followed by a PM pulse capture 1.
- R7: While any of `lop_i`, `ais_i`, `lom_i` or `auto_ais_i` is high, the running and holding counts read 0 from the next cycle on. Events and PM pulses in that time have no effect.
- R8: An event in the same cycle as a PM pulse is not part of the captured value. It becomes the first count of the new period, which leaves the running count at 1.
- R9: Increment and decrement strobes in the same cycle are each counted by their own counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inc_i | input | 1 | Pointer increment event strobe |
| dec_i | input | 1 | Pointer decrement event strobe |
| pm_pulse_i | input | 1 | PM boundary pulse: capture and clear |
| sat_en_i | input | 1 | 1 = saturate at maximum, 0 = roll over |
| lop_i | input | 1 | Loss of pointer alarm level |
| ais_i | input | 1 | Tributary AIS alarm level |
| lom_i | input | 1 | Loss of multiframe alignment alarm level |
| auto_ais_i | input | 1 | Automatic AIS request level |
| inc_hold_o | output | 4 | Captured increment count |
| dec_hold_o | output | 4 | Captured decrement count |

## Verification
Some rules can be checked on every cycle, so assertions cover them:
- the capture of the running count on a pulse;
- the clear, which also takes in a coincident event;
- stability of the holding values between pulses;
- saturation and wrap at the maximum;
- independence of the two counters;
- zeroing under any alarm.

Other behaviour only shows up over a sequence of stimuli, so the bench scenarios cover it. These include the overflow results after long event runs, the captured values of simultaneous increment and decrement streams, each alarm source acting on its own, and a PM pulse that is ignored during an alarm.

// File: rtl/ptr_just_cnt_pkg.sv
package ptr_just_cnt_pkg;
  localparam int unsigned CNT_W   = 4;
  localparam int unsigned ALARM_N = 4;
  localparam int unsigned EVT_N   = 2;

  typedef enum int unsigned {
    ALM_LOP  = 0,
    ALM_AIS  = 1,
    ALM_LOM  = 2,
    ALM_AUTO = 3
  } alarm_idx_e;

  typedef enum int unsigned {
    EVT_INC = 0,
    EVT_DEC = 1
  } evt_idx_e;
endpackage

// File: rtl/pjc_alarm_merge.sv
module pjc_alarm_merge #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] alm_i,
  output logic         any_o
);
  assign any_o = |alm_i;
endmodule

// File: rtl/pjc_event_counter.sv
module pjc_event_counter #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         ev_i,
  input  logic         cap_i,
  input  logic         sat_i,
  output logic [W-1:0] run_o,
  output logic [W-1:0] hold_o
);
  localparam logic [W-1:0] MAX_V = {W{1'b1}};
  localparam logic [W-1:0] ONE_V = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] run_q, run_d, hold_q, hold_d, run_inc;

  // saturating or wrapping increment
  always_comb begin
    if (sat_i && run_q == MAX_V) run_inc = run_q;
    else                         run_inc = run_q + ONE_V;
  end

  always_comb begin
    run_d  = run_q;
    hold_d = hold_q;
    if (clr_i) begin
      run_d  = '0;
      hold_d = '0;
    end else if (cap_i) begin
      hold_d = run_q;
      run_d  = ev_i ? ONE_V : '0;  // coincident event opens new period
    end else if (ev_i) begin
      run_d = run_inc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      hold_q <= '0;
    end else begin
      run_q  <= run_d;
      hold_q <= hold_d;
    end
  end

  assign run_o  = run_q;
  assign hold_o = hold_q;
endmodule

// File: rtl/ptr_just_cnt.sv
module ptr_just_cnt
  import ptr_just_cnt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  input  logic             pm_pulse_i,
  input  logic             sat_en_i,
  input  logic             lop_i,
  input  logic             ais_i,
  input  logic             lom_i,
  input  logic             auto_ais_i,
  output logic [CNT_W-1:0] inc_hold_o,
  output logic [CNT_W-1:0] dec_hold_o
);
  logic [ALARM_N-1:0] alm_vec;
  logic               alarm_any;
  logic [EVT_N-1:0]   ev_vec;
  logic [CNT_W-1:0]   run_cnt  [EVT_N];
  logic [CNT_W-1:0]   hold_cnt [EVT_N];

  always_comb begin
    alm_vec           = '0;
    alm_vec[ALM_LOP]  = lop_i;
    alm_vec[ALM_AIS]  = ais_i;
    alm_vec[ALM_LOM]  = lom_i;
    alm_vec[ALM_AUTO] = auto_ais_i;
    ev_vec            = '0;
    ev_vec[EVT_INC]   = inc_i;
    ev_vec[EVT_DEC]   = dec_i;
  end

  pjc_alarm_merge #(.N(ALARM_N)) u_alarm (
    .alm_i (alm_vec),
    .any_o (alarm_any)
  );

  for (genvar g = 0; g < EVT_N; g++) begin : g_cnt
    pjc_event_counter #(.W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (alarm_any),
      .ev_i   (ev_vec[g]),
      .cap_i  (pm_pulse_i),
      .sat_i  (sat_en_i),
      .run_o  (run_cnt[g]),
      .hold_o (hold_cnt[g])
    );
  end

  assign inc_hold_o = hold_cnt[EVT_INC];
  assign dec_hold_o = hold_cnt[EVT_DEC];
endmodule

// File: rtl/ptr_just_cnt_chk.sv
module ptr_just_cnt_chk
  import ptr_just_cnt_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             inc_i,
  input logic             dec_i,
  input logic             pm_pulse_i,
  input logic             sat_en_i,
  input logic             lop_i,
  input logic             ais_i,
  input logic             lom_i,
  input logic             auto_ais_i,
  input logic [CNT_W-1:0] inc_hold_o,
  input logic [CNT_W-1:0] dec_hold_o,
  input logic [CNT_W-1:0] run_inc,
  input logic [CNT_W-1:0] run_dec
);
  localparam logic [CNT_W-1:0] MAXC = {CNT_W{1'b1}};
  logic alm;
  assign alm = lop_i | ais_i | lom_i | auto_ais_i;

  AST_ALARM_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alm |=> (inc_hold_o == '0 && dec_hold_o == '0 && run_inc == '0 && run_dec == '0)); // R7
  AST_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pm_pulse_i && !alm) |=> (inc_hold_o == $past(run_inc) && dec_hold_o == $past(run_dec))); // R3
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pm_pulse_i && !alm) |=> ($stable(inc_hold_o) && $stable(dec_hold_o))); // R3
  AST_RUN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pm_pulse_i && !alm) |=> (run_inc == {{(CNT_W-1){1'b0}}, $past(inc_i)})); // R4 R8
  AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pm_pulse_i && !alm && sat_en_i && run_inc == MAXC) |=> (run_inc == MAXC)); // R5
  AST_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pm_pulse_i && !alm && !sat_en_i && inc_i && run_inc == MAXC) |=> (run_inc == '0)); // R6
  AST_INC_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pm_pulse_i && !alm && !inc_i) |=> $stable(run_inc)); // R1
  AST_DEC_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pm_pulse_i && !alm && !dec_i) |=> $stable(run_dec)); // R1
  AST_BOTH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pm_pulse_i && !alm && !sat_en_i && inc_i && dec_i) |=>
      (run_inc == $past(run_inc) + 1'b1 && run_dec == $past(run_dec) + 1'b1)); // R9
endmodule

bind ptr_just_cnt ptr_just_cnt_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .inc_i      (inc_i),
  .dec_i      (dec_i),
  .pm_pulse_i (pm_pulse_i),
  .sat_en_i   (sat_en_i),
  .lop_i      (lop_i),
  .ais_i      (ais_i),
  .lom_i      (lom_i),
  .auto_ais_i (auto_ais_i),
  .inc_hold_o (inc_hold_o),
  .dec_hold_o (dec_hold_o),
  .run_inc    (run_cnt[0]),
  .run_dec    (run_cnt[1])
);

// File: tb/ptr_just_cnt_tb.sv
module ptr_just_cnt_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  typedef struct packed {
    logic [7:0] n_inc;
    logic [7:0] n_dec;
    logic       sat;
    logic [3:0] exp_inc;
    logic [3:0] exp_dec;
  } vec_t;

  // n_inc, n_dec, sat, expected inc hold, expected dec hold
  localparam vec_t VECS [NV] = '{
    '{8'd3,  8'd0,  1'b0, 4'd3,  4'd0},
    '{8'd3,  8'd5,  1'b0, 4'd3,  4'd5},
    '{8'd15, 8'd15, 1'b1, 4'd15, 4'd15},
    '{8'd20, 8'd7,  1'b1, 4'd15, 4'd7},
    '{8'd16, 8'd0,  1'b0, 4'd0,  4'd0},
    '{8'd17, 8'd33, 1'b0, 4'd1,  4'd1},
    '{8'd40, 8'd16, 1'b1, 4'd15, 4'd15},
    '{8'd9,  8'd18, 1'b0, 4'd9,  4'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic inc = 1'b0, dec = 1'b0, pm = 1'b0, sat = 1'b0;
  logic lop = 1'b0, ais = 1'b0, lom = 1'b0, aais = 1'b0;
  logic [3:0] inc_hold, dec_hold;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptr_just_cnt u_dut (
    .clk_i(clk), .rst_ni(rst_n), .inc_i(inc), .dec_i(dec), .pm_pulse_i(pm),
    .sat_en_i(sat), .lop_i(lop), .ais_i(ais), .lom_i(lom), .auto_ais_i(aais),
    .inc_hold_o(inc_hold), .dec_hold_o(dec_hold)
  );

  task automatic check(string req, logic [3:0] ei, logic [3:0] ed);
    n_chk++;
    if (inc_hold !== ei || dec_hold !== ed) begin
      n_fail++;
      $display("FAIL %s: inc_hold=%0d dec_hold=%0d expected %0d %0d", req, inc_hold, dec_hold, ei, ed);
    end
  endtask

  // one cycle of stimulus, driven at negedge
  task automatic step(logic i, logic d, logic p);
    inc = i; dec = d; pm = p;
    @(negedge clk);
    inc = 1'b0; dec = 1'b0; pm = 1'b0;
  endtask

  task automatic set_alarm(int k, logic v);
    case (k)
      0: lop = v;
      1: ais = v;
      2: lom = v;
      default: aais = v;
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check("R2 reset", 4'd0, 4'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 after release", 4'd0, 4'd0);

    // table walk: R1 R3 R4 R5 R6 R9
    for (int v = 0; v < NV; v++) begin
      sat = VECS[v].sat;
      step(1'b0, 1'b0, 1'b1);  // flush running counts
      for (int c = 0; c < 40; c++)
        step(c < int'(VECS[v].n_inc), c < int'(VECS[v].n_dec), 1'b0);
      step(1'b0, 1'b0, 1'b1);
      check($sformatf("R3 R5 R6 R9 vector %0d", v), VECS[v].exp_inc, VECS[v].exp_dec);
      step(1'b0, 1'b0, 1'b1);
      check($sformatf("R4 cleared after vector %0d", v), 4'd0, 4'd0);
    end

    // R8: event coincident with PM pulse
    sat = 1'b0;
    step(1'b0, 1'b0, 1'b1);
    repeat (5) step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b1);
    check("R8 capture excludes coincident event", 4'd5, 4'd0);
    step(1'b0, 1'b0, 1'b1);
    check("R8 coincident event starts new period", 4'd1, 4'd1);

    // R3: holding value stable between pulses
    repeat (7) step(1'b1, 1'b1, 1'b0);
    check("R3 hold stable between pulses", 4'd1, 4'd1);

    // R7: each alarm source alone
    for (int k = 0; k < 4; k++) begin
      step(1'b0, 1'b0, 1'b1);
      repeat (4) step(1'b1, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b1);
      check($sformatf("R7 setup alarm %0d", k), 4'd4, 4'd0);
      repeat (3) step(1'b1, 1'b1, 1'b0);
      set_alarm(k, 1'b1);
      @(negedge clk);
      check($sformatf("R7 alarm %0d zeroes hold", k), 4'd0, 4'd0);
      step(1'b1, 1'b1, 1'b1);  // ignored under alarm
      check($sformatf("R7 alarm %0d pulse ignored", k), 4'd0, 4'd0);
      set_alarm(k, 1'b0);
      step(1'b0, 1'b0, 1'b1);
      check($sformatf("R7 alarm %0d running zeroed", k), 4'd0, 4'd0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule